// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block multiplies a 12-bit signed operand by an 8-bit signed operand and keeps a 27-bit running sum of the products. The multiply and the add are two separate clocked stages. When the new-data qualifier is high, the multiplier stage registers the 20-bit product and raises a one-cycle ready strobe. The accumulator stage adds that product into its sum only in the cycle the strobe is high.

If the sum would leave the 27-bit two's-complement range, it is held at the nearest limit instead of wrapping around. The limit is +2^26-1 for positive overflow and -2^26 for negative overflow. To detect this, the block adds in a 28-bit check value. A sticky flag records that clamping has happened. A synchronous clear empties the sum, the pending product, the ready strobe and the flag. An asynchronous active-low reset puts the block in the same empty state.

Top module: `smac_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `acc_q` reads 0 and `sat_flag` reads 0 until the first accumulation.
- R2: Both operands are two's-complement. Each accepted pair adds the signed product `op_a*op_b` to the signed value of `acc_q`.
- R3: A pair sampled with `nd`=1 on rising edge k shows up in `acc_q` right after rising edge k+1 and not earlier. `nd` high on consecutive edges accumulates every pair.
- R4: On an edge where no product is pending (because `nd` was 0 on the previous edge), `acc_q` and `sat_flag` keep their values.
- R5: `clr`=1 at a rising edge sets `acc_q` to 0 and `sat_flag` to 0. This takes priority over a product that is pending in the same cycle, and that product is discarded.
- R6: A pair presented with `nd`=1 on the same edge as `clr`=1 is discarded and never reaches `acc_q`.
- R7: If the true sum is above 2^26-1, `acc_q` becomes 2^26-1 (0x3FFFFFF).
- R8: If the true sum is below -2^26, `acc_q` becomes -2^26 (0x4000000).
- R9: `sat_flag` goes to 1 on any edge where R7 or R8 clamps. It then stays 1, whatever later products arrive, until a clear.
- R10: After a clamp, later products are added to the limit value. A product of opposite sign therefore moves `acc_q` back inside the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of sum, pending product and flag |
| nd | input | 1 | New-data qualifier for the operand pair |
| op_a | input | 12 | Signed multiplicand |
| op_b | input | 8 | Signed multiplier |
| acc_q | output | 27 | Signed accumulated sum |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
The assertions assume that `clr`, `nd` and the operands are known values at every rising edge once reset has been released. They also assume that reset is applied only through `rst_n`. The monotonic properties assume that a product is pending only if it was loaded by an `nd` sample. The bench changes all inputs on falling edges and keeps them at defined values throughout. It never drives X or Z, so every sampled edge falls inside these assumptions. The sweeps cover every `op_a` value and every `op_b` value. Long runs of the largest products of each sign drive the sum into both limits, and short follow-up sequences recover from the limits and clear.

// File: rtl/smac_pkg.sv
package smac_pkg;
  localparam int unsigned OPA_W_DEF = 12;
  localparam int unsigned OPB_W_DEF = 8;
  localparam int unsigned SUM_W_DEF = 27;

  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_HI   = 2'd1,
    CLAMP_LO   = 2'd2
  } clamp_kind_e;
endpackage

// File: rtl/smac_mult_stage.sv
module smac_mult_stage #(
  parameter int unsigned OPA_W = 12,
  parameter int unsigned OPB_W = 8,
  localparam int unsigned PROD_W = OPA_W + OPB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              nd,
  input  logic [OPA_W-1:0]  op_a,
  input  logic [OPB_W-1:0]  op_b,
  output logic [PROD_W-1:0] prod_q,
  output logic              rdy_q
);
  logic [PROD_W-1:0] prod_d;
  logic              prod_en;
  logic              rdy_d;

  always_comb begin
    prod_en = clr | nd;
    rdy_d   = nd & ~clr;
    if (clr) prod_d = '0;
    else     prod_d = PROD_W'($signed(op_a) * $signed(op_b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      if (prod_en) prod_q <= prod_d;
    end
  end

  // R3
  rdy_after_nd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nd && !clr) |=> rdy_q);
  // R6
  rdy_killed_by_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rdy_q);
endmodule

// File: rtl/smac_sat_add.sv
module smac_sat_add
  import smac_pkg::*;
#(
  parameter int unsigned PROD_W = 20,
  parameter int unsigned SUM_W  = 27,
  localparam int unsigned CHK_W = SUM_W + 1
) (
  input  logic [SUM_W-1:0]  acc_in,
  input  logic [PROD_W-1:0] prod_in,
  output logic [SUM_W-1:0]  sum_out,
  output clamp_kind_e       kind
);
  localparam logic [SUM_W-1:0] POS_LIM = {1'b0, {(SUM_W-1){1'b1}}};
  localparam logic [SUM_W-1:0] NEG_LIM = {1'b1, {(SUM_W-1){1'b0}}};

  logic [CHK_W-1:0] acc_ext;
  logic [CHK_W-1:0] prod_ext;
  logic [CHK_W-1:0] chk;

  generate
    if (PROD_W >= CHK_W) begin : g_prod_trunc
      assign prod_ext = prod_in[CHK_W-1:0];
    end else begin : g_prod_sext
      assign prod_ext = {{(CHK_W-PROD_W){prod_in[PROD_W-1]}}, prod_in};
    end
  endgenerate

  always_comb begin
    acc_ext = {acc_in[SUM_W-1], acc_in};
    chk     = acc_ext + prod_ext;
    if (chk[CHK_W-1] == chk[CHK_W-2]) begin
      kind    = CLAMP_NONE;
      sum_out = chk[SUM_W-1:0];
    end else if (!chk[CHK_W-1]) begin
      kind    = CLAMP_HI;
      sum_out = POS_LIM;
    end else begin
      kind    = CLAMP_LO;
      sum_out = NEG_LIM;
    end
  end
endmodule

// File: rtl/smac_accum.sv
module smac_accum
  import smac_pkg::*;
#(
  parameter int unsigned PROD_W  = 20,
  parameter int unsigned SUM_W   = 27,
  parameter bit          FLAG_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rdy,
  input  logic [PROD_W-1:0] prod,
  output logic [SUM_W-1:0]  acc_q,
  output logic              sat_flag
);
  logic [SUM_W-1:0] sum_nx;
  logic [SUM_W-1:0] acc_d;
  logic             acc_en;
  clamp_kind_e      kind;

  smac_sat_add #(.PROD_W(PROD_W), .SUM_W(SUM_W)) u_sat_add (
    .acc_in  (acc_q),
    .prod_in (prod),
    .sum_out (sum_nx),
    .kind    (kind)
  );

  always_comb begin
    acc_en = clr | rdy;
    acc_d  = clr ? '0 : sum_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  generate
    if (FLAG_EN) begin : g_flag
      logic flag_d;
      logic flag_en;
      always_comb begin
        flag_en = clr | (rdy & (kind != CLAMP_NONE));
        flag_d  = ~clr;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sat_flag <= 1'b0;
        else if (flag_en) sat_flag <= flag_d;
      end

      // R9
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !clr) |=> sat_flag);
    end else begin : g_noflag
      assign sat_flag = 1'b0;
    end
  endgenerate

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && !clr) |=> $stable(acc_q));
  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0) && !sat_flag);
  // R7
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !clr && !prod[PROD_W-1]) |=> ($signed(acc_q) >= $signed($past(acc_q))));
  // R8
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !clr && prod[PROD_W-1]) |=> ($signed(acc_q) <= $signed($past(acc_q))));
endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int unsigned OPA_W   = OPA_W_DEF,
  parameter int unsigned OPB_W   = OPB_W_DEF,
  parameter int unsigned SUM_W   = SUM_W_DEF,
  parameter bit          FLAG_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             nd,
  input  logic [OPA_W-1:0] op_a,
  input  logic [OPB_W-1:0] op_b,
  output logic [SUM_W-1:0] acc_q,
  output logic             sat_flag
);
  localparam int unsigned PROD_W = OPA_W + OPB_W;

  logic [PROD_W-1:0] prod_q;
  logic              rdy_q;

  smac_mult_stage #(.OPA_W(OPA_W), .OPB_W(OPB_W)) u_mult (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .nd     (nd),
    .op_a   (op_a),
    .op_b   (op_b),
    .prod_q (prod_q),
    .rdy_q  (rdy_q)
  );

  smac_accum #(.PROD_W(PROD_W), .SUM_W(SUM_W), .FLAG_EN(FLAG_EN)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .rdy      (rdy_q),
    .prod     (prod_q),
    .acc_q    (acc_q),
    .sat_flag (sat_flag)
  );
endmodule

// File: tb/smac_unit_bench.sv
module smac_unit_bench;
  localparam int CLK_P = 10;
  localparam longint MAXV = (longint'(1) <<< 26) - 1;
  localparam longint MINV = -(longint'(1) <<< 26);

  logic clk = 1'b0;
  logic rst_n, clr, nd;
  logic signed [11:0] op_a;
  logic signed [7:0]  op_b;
  logic [26:0] acc_q;
  logic        sat_flag;

  int checks = 0;
  int errors = 0;

  longint m_acc, m_prod;
  logic   m_rdy, m_flag;

  always #(CLK_P/2) clk = ~clk;

  smac_unit u_smac_unit (
    .clk(clk), .rst_n(rst_n), .clr(clr), .nd(nd),
    .op_a(op_a), .op_b(op_b), .acc_q(acc_q), .sat_flag(sat_flag)
  );

  task automatic check_out(input string tag);
    longint got;
    got = longint'($signed(acc_q));
    checks++;
    if (got != m_acc) begin
      errors++;
      $display("FAIL %s acc_q actual=%0d expected=%0d", tag, got, m_acc);
    end
    checks++;
    if (sat_flag !== m_flag) begin
      errors++;
      $display("FAIL %s sat_flag actual=%0b expected=%0b", tag, sat_flag, m_flag);
    end
  endtask

  task automatic step(input logic c, input logic n, input int a, input int b,
                      input string tag);
    longint s;
    @(negedge clk);
    clr = c; nd = n; op_a = 12'(a); op_b = 8'(b);
    @(posedge clk);
    if (c) begin
      m_acc = 0; m_flag = 1'b0; m_rdy = 1'b0; m_prod = 0;
    end else begin
      if (m_rdy) begin
        s = m_acc + m_prod;
        if (s > MAXV) begin m_acc = MAXV; m_flag = 1'b1; end
        else if (s < MINV) begin m_acc = MINV; m_flag = 1'b1; end
        else m_acc = s;
      end
      m_rdy = n;
      if (n) m_prod = longint'(op_a) * longint'(op_b);
    end
    #(CLK_P/4);
    check_out(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired for all requirements actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; nd = 1'b0; op_a = '0; op_b = '0;
    m_acc = 0; m_prod = 0; m_rdy = 1'b0; m_flag = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check_out("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 0, 0, "R1 after release");

    // R2: every op_a value against a rotating op_b, with idle gaps (R4)
    for (int ia = -2048; ia < 2048; ia++) begin
      int bsel;
      bsel = (ia + 2048) % 7;
      step(1'b0, ((ia & 3) != 3), ia,
           (bsel == 0) ? -128 : (bsel == 1) ? -1 : (bsel == 2) ? 0 :
           (bsel == 3) ? 1 : (bsel == 4) ? 127 : (bsel == 5) ? -77 : 53,
           ((ia & 3) == 3) ? "R4 idle" : "R2 sweep a");
    end
    step(1'b1, 1'b0, 0, 0, "R5 clear");
    // R2: every op_b value against fixed op_a
    for (int ib = -128; ib < 128; ib++) step(1'b0, 1'b1, -1371, ib, "R2 sweep b");
    for (int ib = -128; ib < 128; ib++) step(1'b0, 1'b1, 2047, ib, "R2 sweep b");

    // R5: clear overrides a pending product
    step(1'b0, 1'b1, 100, 100, "R5 load");
    step(1'b1, 1'b0, 0, 0, "R5 clr vs pending");
    step(1'b0, 1'b0, 0, 0, "R5 pending dropped");
    // R6: pair offered with clear is discarded
    step(1'b1, 1'b1, 5, 5, "R6 clr with nd");
    step(1'b0, 1'b0, 0, 0, "R6 no add");
    step(1'b0, 1'b0, 0, 0, "R6 no add");

    // R3 latency
    step(1'b0, 1'b1, 3, 4, "R3 not yet");
    step(1'b0, 1'b1, -7, 9, "R3 first");
    step(1'b0, 1'b0, 0, 0, "R3 second");

    // R7/R9: drive into positive limit
    step(1'b1, 1'b0, 0, 0, "R5 clear");
    for (int k = 0; k < 300; k++) step(1'b0, 1'b1, -2048, -128, "R7 pos clamp");
    step(1'b0, 1'b0, 0, 0, "R7 pos clamp");
    step(1'b0, 1'b0, 0, 0, "R4 hold at limit");
    step(1'b0, 1'b1, -1, 1, "R10 leave pos limit");
    step(1'b0, 1'b0, 0, 0, "R10 leave pos limit");
    step(1'b0, 1'b1, 1, 1, "R9 sticky");
    step(1'b0, 1'b0, 0, 0, "R9 sticky");

    // R8/R9: drive into negative limit
    step(1'b1, 1'b0, 0, 0, "R5 clear flag");
    for (int k = 0; k < 300; k++) step(1'b0, 1'b1, -2048, 127, "R8 neg clamp");
    step(1'b0, 1'b0, 0, 0, "R8 neg clamp");
    step(1'b0, 1'b1, 1, 1, "R10 leave neg limit");
    step(1'b0, 1'b0, 0, 0, "R10 leave neg limit");
    step(1'b0, 1'b1, 0, 5, "R9 sticky");
    step(1'b0, 1'b0, 0, 0, "R9 sticky");
    step(1'b1, 1'b0, 0, 0, "R5 final clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule